// File: doc/BRIEF.md
# Auxiliary Domain Clock Controller

This block produces the clock of an auxiliary power domain. It chooses between a slow free-running clock and a fast clock. The fast clock first passes through a power-of-two divider. The choice comes from a 32-bit control word. It is written through a plain write strobe in a configuration clock domain, and every bit written is held for read-back. A two-input switch makes each handover between sources free of glitches.

The switch works like this. An input may be enabled only after the other input's enable has been seen low. Each enable is re-timed by two flops on the falling edge of its own clock.

The domain signals the power state with two inputs: a power-down request and an active indication. If the domain is powered down while the fast path is selected, the block moves by itself to the configured power-down source. That source is either the slow clock or no clock at all. The block returns to the fast path once the domain reports that it is active again. A status output shows which source drives the output once a handover has completed.

Top module: `aux_clk_ctrl`

## Requirements
- R1: After reset the control word reads 0, the error flag is 0 and the output runs from the slow clock. A write stores all 32 bits, which read back unchanged one configuration cycle later. Without a write, the word holds its value.
- R2: Source code 1 in bits [2:0] selects the divided fast clock, and the status reads 2'b10.
- R3: Source code 4 in bits [2:0] selects the slow clock, and the status reads 2'b01.
- R4: The divider code n in bits [10:8] gives an output period of 2^(n+1) fast-clock periods, with a 50% duty cycle.
- R5: Any other source code leaves the current selection unchanged. It sets the error flag, which then stays set until reset.
- R6: A divider code written while the fast path drives the output has no effect. It is applied when the path is next deselected, and it holds when the fast path is selected again.
- R7: A power-down request latches a power-down state. The state clears when the domain reports active with no request pending. While the state is set, the fast source is selected, and bits [12:11] equal 1, the output runs from the slow clock and the status reads 2'b01. When the state clears, the output returns to the divided fast clock.
- R8: In the same situation with bits [12:11] not equal to 1, the output is held low and the status reads 2'b00 until the state clears.
- R9: While the slow clock is selected, power-down has no effect on the output.
- R10: The output never shows a high or low pulse shorter than half the period of the faster of the two clocks involved.
- R11: The status never reads 2'b11. It reads 2'b00 during a handover and shows the new source only after that source's enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Configuration clock for the control word and the power-state inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_hf | input | 1 | Fast source clock |
| clk_lf | input | 1 | Slow source clock |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| pd_req | input | 1 | Power-down request from the domain (clk_cfg domain) |
| dom_active | input | 1 | Domain reports active (clk_cfg domain) |
| clk_aux | output | 1 | Generated auxiliary clock |
| src_status | output | 2 | Driving source: 00 none, 01 slow, 10 fast |
| sel_err | output | 1 | Sticky flag: a reserved source code was written |

## Verification
A wrong internal state shows at the ports as a wrong output period, a wrong status code, or a short pulse on clk_aux. A stuck enable or a wrong divider code changes the measured period within a few output cycles after a handover settles. A broken cross-enable either lets both enables rise, giving status 11 at once, or produces a short pulse that the pulse-width monitor catches at the edge where it occurs. Errors in the control word or the flag show at the next configuration cycle.

// File: rtl/aux_clk_pkg.sv
package aux_clk_pkg;
  localparam int CFG_W   = 32;
  localparam int SRC_LSB = 0;
  localparam int SRC_W   = 3;
  localparam int DIV_LSB = 8;
  localparam int DIV_W   = 3;
  localparam int PDS_LSB = 11;
  localparam int PDS_W   = 2;

  localparam logic [SRC_W-1:0] SRC_CODE_HF = 3'd1;
  localparam logic [SRC_W-1:0] SRC_CODE_LF = 3'd4;
  localparam logic [PDS_W-1:0] PDS_CODE_LF = 2'd1;

  typedef enum logic [1:0] {
    STAT_NONE = 2'b00,
    STAT_LF   = 2'b01,
    STAT_HF   = 2'b10
  } aux_stat_e;
endpackage

// File: rtl/aux_clk_rst_sync.sv
module aux_clk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/aux_clk_ctrl_reg.sv
module aux_clk_ctrl_reg
  import aux_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             pd_req,
  input  logic             dom_active,
  output logic [CFG_W-1:0] rdata,
  output logic             err,
  output logic [DIV_W-1:0] div_code,
  output logic             want_hf,
  output logic             want_lf
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             sel_hf_q, sel_hf_d;
  logic             err_q, err_d;
  logic             pd_q, pd_d;
  logic [SRC_W-1:0] wr_src;
  logic             pds_lf;

  assign wr_src = wdata[SRC_LSB +: SRC_W];

  always_comb begin
    cfg_d    = cfg_q;
    sel_hf_d = sel_hf_q;
    err_d    = err_q;
    if (we) begin
      cfg_d = wdata;
      if (wr_src == SRC_CODE_HF)      sel_hf_d = 1'b1;
      else if (wr_src == SRC_CODE_LF) sel_hf_d = 1'b0;
      else                            err_d    = 1'b1;
    end
    if (pd_req)          pd_d = 1'b1;
    else if (dom_active) pd_d = 1'b0;
    else                 pd_d = pd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      sel_hf_q <= 1'b0;
      err_q    <= 1'b0;
      pd_q     <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      sel_hf_q <= sel_hf_d;
      err_q    <= err_d;
      pd_q     <= pd_d;
    end
  end

  assign pds_lf   = (cfg_q[PDS_LSB +: PDS_W] == PDS_CODE_LF);
  assign rdata    = cfg_q;
  assign err      = err_q;
  assign div_code = cfg_q[DIV_LSB +: DIV_W];
  assign want_hf  = sel_hf_q & ~pd_q;
  assign want_lf  = ~sel_hf_q | (pd_q & pds_lf);
endmodule

// File: rtl/aux_clk_hf_div.sv
module aux_clk_hf_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code,
  input  logic             in_use,
  output logic             clk_div
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] code_q, code_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             div_q, div_d;
  logic             wrap;

  assign lim  = (CNT_W'(1) << code_q) - CNT_W'(1);
  assign wrap = (cnt_q >= lim);

  always_comb begin
    code_d = in_use ? code_q : div_code;
    cnt_d  = wrap ? '0 : cnt_q + CNT_W'(1);
    div_d  = wrap ? ~div_q : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
    end
  end

  assign clk_div = div_q;
endmodule

// File: rtl/aux_clk_gf_mux.sv
module aux_clk_gf_mux #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic [N-1:0] clk_in,
  input  logic [N-1:0] rst_n_in,
  input  logic [N-1:0] want,
  output logic [N-1:0] en,
  output logic         clk_out
);
  for (genvar i = 0; i < N; i++) begin : g_leg
    localparam logic [N-1:0] SELF = N'(1) << i;
    logic              req;
    logic [STAGES-1:0] sync_q, sync_d;

    assign req    = want[i] & ~|(en & ~SELF);
    assign sync_d = {sync_q[STAGES-2:0], req};

    always_ff @(negedge clk_in[i] or negedge rst_n_in[i]) begin
      if (!rst_n_in[i]) sync_q <= '0;
      else              sync_q <= sync_d;
    end

    assign en[i] = sync_q[STAGES-1];
  end

  assign clk_out = |(clk_in & en);
endmodule

// File: rtl/aux_clk_ctrl.sv
module aux_clk_ctrl
  import aux_clk_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_cfg,
  input  logic        rst_n,
  input  logic        clk_hf,
  input  logic        clk_lf,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        pd_req,
  input  logic        dom_active,
  output logic        clk_aux,
  output logic [1:0]  src_status,
  output logic        sel_err
);
  localparam int LEG_LF = 0;
  localparam int LEG_HF = 1;

  logic             rst_cfg_n, rst_hf_n, rst_lf_n;
  logic             want_hf, want_lf;
  logic [DIV_W-1:0] div_code;
  logic             clk_div;
  logic [1:0]       leg_en;

  aux_clk_rst_sync #(.STAGES(RST_STAGES)) u_rst_cfg (
    .clk(clk_cfg), .rst_n(rst_n), .rst_sync_n(rst_cfg_n));
  aux_clk_rst_sync #(.STAGES(RST_STAGES)) u_rst_hf (
    .clk(clk_hf), .rst_n(rst_n), .rst_sync_n(rst_hf_n));
  aux_clk_rst_sync #(.STAGES(RST_STAGES)) u_rst_lf (
    .clk(clk_lf), .rst_n(rst_n), .rst_sync_n(rst_lf_n));

  aux_clk_ctrl_reg u_reg (
    .clk        (clk_cfg),
    .rst_n      (rst_cfg_n),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .pd_req     (pd_req),
    .dom_active (dom_active),
    .rdata      (cfg_rdata),
    .err        (sel_err),
    .div_code   (div_code),
    .want_hf    (want_hf),
    .want_lf    (want_lf)
  );

  aux_clk_hf_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk_hf),
    .rst_n    (rst_hf_n),
    .div_code (div_code),
    .in_use   (leg_en[LEG_HF]),
    .clk_div  (clk_div)
  );

  aux_clk_gf_mux #(.N(2), .STAGES(SYNC_STAGES)) u_mux (
    .clk_in   ({clk_div, clk_lf}),
    .rst_n_in ({rst_hf_n, rst_lf_n}),
    .want     ({want_hf, want_lf}),
    .en       (leg_en),
    .clk_out  (clk_aux)
  );

  assign src_status = {leg_en[LEG_HF], leg_en[LEG_LF]};
endmodule

// File: rtl/aux_clk_ctrl_chk.sv
module aux_clk_ctrl_chk (
  input logic        clk_cfg,
  input logic        rst_cfg_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        sel_err,
  input logic [1:0]  src_status,
  input logic        clk_aux
);
  AST_RDATA_FOLLOWS_WRITE: assert property (@(posedge clk_cfg) disable iff (!rst_cfg_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R1
  AST_RDATA_HOLDS: assert property (@(posedge clk_cfg) disable iff (!rst_cfg_n)
    !cfg_we |=> $stable(cfg_rdata)); // R1
  AST_RSVD_SETS_ERR: assert property (@(posedge clk_cfg) disable iff (!rst_cfg_n)
    (cfg_we && cfg_wdata[2:0] != 3'd1 && cfg_wdata[2:0] != 3'd4) |=> sel_err); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_cfg) disable iff (!rst_cfg_n)
    sel_err |=> sel_err); // R5
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk_cfg) disable iff (!rst_cfg_n)
    $countones(src_status) <= 1); // R11
  AST_NONE_HOLDS_LOW: assert property (@(posedge clk_cfg) disable iff (!rst_cfg_n)
    (src_status == 2'b00) |-> !clk_aux); // R8
endmodule

bind aux_clk_ctrl aux_clk_ctrl_chk u_chk (
  .clk_cfg    (clk_cfg),
  .rst_cfg_n  (rst_cfg_n),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .sel_err    (sel_err),
  .src_status (src_status),
  .clk_aux    (clk_aux)
);

// File: tb/aux_clk_ctrl_tb.sv
`timescale 1ns/1ps
module aux_clk_ctrl_tb;
  localparam int HF_P = 6;
  localparam int LF_P = 50;
  localparam real MIN_PULSE = 5.5;
  localparam int E_NONE = 0;
  localparam int E_LF = 1;
  localparam int E_HF = 2;

  logic        clk_cfg = 1'b0, clk_hf = 1'b0, clk_lf = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        pd_req = 1'b0, dom_active = 1'b1;
  logic [31:0] cfg_rdata;
  logic        clk_aux;
  logic [1:0]  src_status;
  logic        sel_err;

  int checks = 0, fails = 0, glitches = 0;
  realtime last_edge = 0.0;
  bit      seen_edge = 1'b0;

  logic [31:0] m_reg = '0;
  bit          m_sel_hf = 1'b0, m_err = 1'b0, m_pd = 1'b0;
  int          m_div = 0;

  always #5  clk_cfg = ~clk_cfg;
  always #3  clk_hf  = ~clk_hf;
  always #25 clk_lf  = ~clk_lf;

  aux_clk_ctrl u_dut (
    .clk_cfg(clk_cfg), .rst_n(rst_n), .clk_hf(clk_hf), .clk_lf(clk_lf),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pd_req(pd_req), .dom_active(dom_active), .clk_aux(clk_aux),
    .src_status(src_status), .sel_err(sel_err));

  always @(clk_aux) begin
    if (rst_n && seen_edge && ($realtime - last_edge) < MIN_PULSE) glitches++;
    seen_edge = 1'b1;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_src();
    if (!m_sel_hf) return E_LF;
    if (!m_pd) return E_HF;
    return (m_reg[12:11] == 2'd1) ? E_LF : E_NONE;
  endfunction

  function automatic int exp_period(int src, int code);
    if (src == E_HF) return HF_P * (1 << (code + 1));
    if (src == E_LF) return LF_P;
    return 0;
  endfunction

  function automatic int exp_status(int src);
    return (src == E_HF) ? 2 : (src == E_LF) ? 1 : 0;
  endfunction

  task automatic wr(input logic [31:0] v);
    bit was_off;
    was_off = (eff_src() != E_HF);
    @(negedge clk_cfg);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk_cfg);
    cfg_we = 1'b0;
    m_reg = v;
    if (v[2:0] == 3'd1) m_sel_hf = 1'b1;
    else if (v[2:0] == 3'd4) m_sel_hf = 1'b0;
    else m_err = 1'b1;
    if (was_off) m_div = int'(v[10:8]);
  endtask

  task automatic settle();
    repeat (900) @(negedge clk_cfg);
    if (eff_src() != E_HF) m_div = int'(m_reg[10:8]);
  endtask

  task automatic measure(output int per, output int edges);
    realtime t[3];
    logic prev;
    edges = 0;
    per = 0;
    #0.5;
    prev = clk_aux;
    for (int s = 0; s < 6000 && edges < 3; s++) begin
      #1;
      if (clk_aux && !prev) begin
        t[edges] = $realtime;
        edges++;
      end
      prev = clk_aux;
    end
    if (edges == 3) per = int'(t[2] - t[1]);
    @(negedge clk_cfg);
  endtask

  task automatic check_out(input string req);
    int per, edges, src;
    src = eff_src();
    measure(per, edges);
    chk(src_status == exp_status(src), req, "status", src_status, exp_status(src));
    if (src == E_NONE) chk(edges == 0, req, "edges while no clock", edges, 0);
    else chk(per == exp_period(src, m_div), req, "period ns", per, exp_period(src, m_div));
  endtask

  task automatic powerdown();
    @(negedge clk_cfg);
    dom_active = 1'b0;
    pd_req = 1'b1;
    @(negedge clk_cfg);
    pd_req = 1'b0;
    m_pd = 1'b1;
  endtask

  task automatic wake();
    @(negedge clk_cfg);
    dom_active = 1'b1;
    m_pd = 1'b0;
  endtask

  initial begin
    #1_800_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_cfg);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_cfg);
    // R1: reset state
    chk(cfg_rdata == 32'd0, "R1", "reset rdata", cfg_rdata, 0);
    chk(sel_err == 1'b0, "R1", "reset error flag", sel_err, 0);
    settle();
    check_out("R1");

    // R2 / R4: fast path with several divider codes
    wr(32'h0000_0001);
    settle();
    chk(cfg_rdata == m_reg, "R1", "readback", cfg_rdata, m_reg);
    check_out("R2");
    wr(32'h0000_0404);
    settle();
    check_out("R3");
    wr(32'h0000_0701);
    settle();
    check_out("R4");

    // R6: divider change while fast path drives has no effect
    wr(32'h0000_0201);
    settle();
    chk(m_div == 7, "R6", "model divider held", m_div, 7);
    check_out("R6");
    wr(32'h0000_0204);
    settle();
    wr(32'h0000_0201);
    settle();
    check_out("R6");

    // R5: reserved source code
    wr(32'h0000_0306);
    repeat (2) @(negedge clk_cfg);
    chk(sel_err == 1'b1, "R5", "error flag set", sel_err, 1);
    chk(cfg_rdata == 32'h0000_0306, "R5", "readback reserved", cfg_rdata, 32'h306);
    settle();
    check_out("R5");

    // R7: power-down to slow clock and back
    wr(32'h0000_0901);
    settle();
    powerdown();
    settle();
    check_out("R7");
    wake();
    settle();
    check_out("R7");

    // R8: power-down with no clock
    wr(32'h0000_1101);
    settle();
    powerdown();
    settle();
    check_out("R8");
    wake();
    settle();
    check_out("R8");

    // R9: power-down while slow clock selected
    wr(32'h0000_0004);
    settle();
    powerdown();
    settle();
    check_out("R9");
    wake();
    settle();

    // Random mix: R2 R3 R4 R5 R11
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 16; it++) begin
      logic [31:0] v;
      int pick;
      v = $urandom();
      v[10:8] = 3'($urandom_range(0, 4));
      pick = $urandom_range(0, 3);
      v[2:0] = (pick < 2) ? 3'd1 : (pick == 2) ? 3'd4 : 3'd6;
      wr(v);
      settle();
      chk(cfg_rdata == m_reg, "R1", "random readback", cfg_rdata, m_reg);
      chk(sel_err == m_err, "R5", "random error flag", sel_err, m_err);
      check_out("R11");
    end

    chk(glitches == 0, "R10", "short pulses", glitches, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule